// File: doc/BRIEF.md
# Window Color Lookup Table

This block keeps one 256-entry table per color channel for each display window. The same storage has two uses, chosen by the pixel mode that comes with each pixel. In an indexed mode (1, 2, 4 or 8 bits per pixel) the index selects one entry, and the red, green and blue entries at that address form the output color, so the table works as a palette. In the true-color mode each 8-bit channel of an already converted RGB pixel addresses its own channel table, and the result is the gamma-corrected channel value.

Software reloads a table through a burst port. A start pulse supplies the target window, a first entry, a length and an override flag. After that, one 16-bit word per channel is accepted in each cycle in which the word strobe is high, and these words fill consecutive entries. Only the upper byte of each word is kept, so an 8-bit value is written by repeating it in both bytes. A length of zero changes only the window's flag. Downstream, a second global table may look up the result again. That stage is not part of this block: a per-pixel output bit states whether the second lookup should take place, and it is high unless the window's override flag is set.

Top module: `win_color_lut`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_rgb` and `upd_busy` are all 0.
- R2: Mode codes 0, 1, 2 and 3 select indexed pixels of 1, 2, 4 and 8 bits. Only the low 1, 2, 4 or 8 bits of `pix_index` are used, zero-extended to form the entry address. The output is red entry in bits 23:16, green in 15:8 and blue in 7:0.
- R3: Mode codes 4 to 7 select true color. `pix_rgb[23:16]` addresses the red table, `[15:8]` the green table and `[7:0]` the blue table, and each result goes to the same bit field of `out_rgb`.
- R4: Each window has its own tables and its own flag. An update to one window never changes what another window returns.
- R5: Each entry written stores bits 15:8 of its update word. Bits 7:0 are ignored.
- R6: A start with a nonzero length, accepted while idle, sets `upd_busy` in the next cycle. Each cycle with `upd_word_valid` high while busy writes the next consecutive entry, beginning at `upd_first`. `upd_busy` falls in the cycle after the last word.
- R7: A start with `upd_len` = 0 updates only the window's override flag. No entry is written and `upd_busy` stays low.
- R8: Writes never pass entry 255. The burst ends after min(`upd_len`, 256 − `upd_first`) words.
- R9: Every accepted start stores `upd_override` for its window. `out_cascade` is 1 when the flag of the pixel's window is clear and 0 when it is set.
- R10: `out_valid`, `out_rgb` and `out_cascade` follow `pix_valid` by exactly one cycle. The output fields hold their values when no pixel arrives. A read in the same cycle as a write to the same entry returns the old contents.
- R11: A start pulse while busy is ignored, and so are update words while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_win | input | WIN_W | Window of the pixel |
| pix_mode | input | 3 | Pixel mode code (R2, R3) |
| pix_index | input | 8 | Palette index for indexed modes |
| pix_rgb | input | 24 | Converted RGB pixel for true-color mode |
| upd_start | input | 1 | Starts an update |
| upd_win | input | WIN_W | Window being updated |
| upd_first | input | 8 | First entry of the burst |
| upd_len | input | 9 | Number of entries (0 to 256) |
| upd_override | input | 1 | New override flag for the window |
| upd_word_valid | input | 1 | Update words are present |
| upd_red | input | 16 | Red update word |
| upd_green | input | 16 | Green update word |
| upd_blue | input | 16 | Blue update word |
| upd_busy | output | 1 | Burst in progress |
| out_valid | output | 1 | Result present |
| out_rgb | output | 24 | Looked-up color |
| out_cascade | output | 1 | Second global lookup requested |

## Verification
Assertions check the timing of the update sequencer on every cycle: busy rises after a nonzero start, stays low after a zero-length start, falls after the last word or at entry 255, and the flags are frozen while a burst runs. They also check the one-cycle alignment and the hold of the output fields. Only the bench can show the stored contents. That covers which byte of a word is kept, how narrow indices are masked, that the three true-color channels are independent, that windows are isolated, and that a read colliding with a write returns the old value. The bench's reference model is compared against the outputs on every clock.

// File: rtl/lut_pkg.sv
`timescale 1ns/1ps
package lut_pkg;
  localparam int LUT_AW    = 8;
  localparam int LUT_DEPTH = 1 << LUT_AW;
  localparam int ENT_W     = 8;
  localparam int UPD_W     = 2 * ENT_W;
  localparam int NUM_CH    = 3;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_IDX1 = 3'd0,
    PM_IDX2 = 3'd1,
    PM_IDX4 = 3'd2,
    PM_IDX8 = 3'd3,
    PM_TRUE = 3'd4
  } pix_mode_e;

  typedef logic [LUT_AW-1:0] lut_addr_t;
  typedef logic [LUT_AW:0]   lut_cnt_t;
  typedef logic [ENT_W-1:0]  ent_t;

  // Modes 0..3 are indexed, the upper half of the code space is true color.
  function automatic logic is_indexed(logic [MODE_W-1:0] m);
    return ~m[MODE_W-1];
  endfunction

  // Zero-extend the significant low bits of an index.
  function automatic lut_addr_t index_addr(logic [MODE_W-1:0] m, lut_addr_t idx);
    lut_addr_t a;
    unique case (m[1:0])
      2'd0:    a = lut_addr_t'(idx[0]);
      2'd1:    a = lut_addr_t'(idx[1:0]);
      2'd2:    a = lut_addr_t'(idx[3:0]);
      default: a = idx;
    endcase
    return a;
  endfunction

  // Number of entries a burst really writes: stops at the last entry.
  function automatic lut_cnt_t clip_len(lut_addr_t first, lut_cnt_t len);
    lut_cnt_t room;
    room = lut_cnt_t'(LUT_DEPTH) - {1'b0, first};
    return (len > room) ? room : len;
  endfunction

  // Only the high byte of an update word is significant.
  function automatic ent_t word_to_entry(logic [UPD_W-1:0] w);
    return w[UPD_W-1 -: ENT_W];
  endfunction
endpackage

// File: rtl/lut_addr_gen.sv
`timescale 1ns/1ps
module lut_addr_gen
  import lut_pkg::*;
(
  input  logic [MODE_W-1:0]       mode,
  input  lut_addr_t               index,
  input  logic [NUM_CH*ENT_W-1:0] rgb,
  output lut_addr_t               addr [NUM_CH]
);
  lut_addr_t idx_a;
  logic      idx_mode;

  assign idx_a    = index_addr(mode, index);
  assign idx_mode = is_indexed(mode);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int HI = (NUM_CH - c) * ENT_W - 1;
    assign addr[c] = idx_mode ? idx_a : lut_addr_t'(rgb[HI -: ENT_W]);
  end
endmodule

// File: rtl/lut_burst_ctl.sv
`timescale 1ns/1ps
module lut_burst_ctl
  import lut_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIN_W-1:0]   s_win,
  input  lut_addr_t          s_first,
  input  lut_cnt_t           s_len,
  input  logic               s_ovr,
  input  logic               word_valid,
  output logic               busy,
  output logic               wr_en,
  output logic [WIN_W-1:0]   wr_win,
  output lut_addr_t          wr_addr,
  output logic [NUM_WIN-1:0] ovr_flags
);
  logic               busy_q;
  lut_addr_t          ptr_q;
  lut_cnt_t           left_q;
  logic [WIN_W-1:0]   win_q;
  logic [NUM_WIN-1:0] ovr_q;

  // Named events, used by the logic and the assertions alike.
  logic     start_take;
  logic     word_take;
  logic     last_take;
  lut_cnt_t eff_len;

  assign start_take = start & ~busy_q;
  assign word_take  = busy_q & word_valid;
  assign last_take  = word_take & (left_q == lut_cnt_t'(1));
  assign eff_len    = clip_len(s_first, s_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
      win_q  <= '0;
      ovr_q  <= '0;
    end else if (start_take) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (s_win == WIN_W'(w)) ovr_q[w] <= s_ovr;
      end
      if (eff_len != '0) begin
        busy_q <= 1'b1;
        ptr_q  <= s_first;
        left_q <= eff_len;
        win_q  <= s_win;
      end
    end else if (word_take) begin
      ptr_q  <= ptr_q + lut_addr_t'(1);
      left_q <= left_q - lut_cnt_t'(1);
      if (last_take) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign wr_en     = word_take;
  assign wr_win    = win_q;
  assign wr_addr   = ptr_q;
  assign ovr_flags = ovr_q;

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && (s_len != '0) |=> busy_q);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !busy_q);
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && (s_len == '0) |=> !busy_q);
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_take && (ptr_q == '1) |=> !busy_q);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(ovr_q));
endmodule

// File: rtl/lut_bank.sv
`timescale 1ns/1ps
module lut_bank
  import lut_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIN_W-1:0] wr_win,
  input  lut_addr_t        wr_addr,
  input  ent_t             wr_data,
  input  logic             rd_en,
  input  logic [WIN_W-1:0] rd_win,
  input  lut_addr_t        rd_addr,
  output ent_t             rd_data
);
  localparam int ENTRIES = NUM_WIN * LUT_DEPTH;
  localparam int MEM_AW  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ent_t mem [ENTRIES];
  ent_t rd_q;

  function automatic logic [MEM_AW-1:0] flat(logic [WIN_W-1:0] w, lut_addr_t a);
    return MEM_AW'(int'(w) * LUT_DEPTH + int'(a));
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[flat(wr_win, wr_addr)] <= wr_data;
  end

  // The read register samples the old contents on a colliding write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[flat(rd_win, rd_addr)];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/win_color_lut.sv
`timescale 1ns/1ps
module win_color_lut
  import lut_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [WIN_W-1:0] pix_win,
  input  logic [2:0]       pix_mode,
  input  logic [7:0]       pix_index,
  input  logic [23:0]      pix_rgb,
  input  logic             upd_start,
  input  logic [WIN_W-1:0] upd_win,
  input  logic [7:0]       upd_first,
  input  logic [8:0]       upd_len,
  input  logic             upd_override,
  input  logic             upd_word_valid,
  input  logic [15:0]      upd_red,
  input  logic [15:0]      upd_green,
  input  logic [15:0]      upd_blue,
  output logic             upd_busy,
  output logic             out_valid,
  output logic [23:0]      out_rgb,
  output logic             out_cascade
);
  logic               busy;
  logic               wr_en;
  logic [WIN_W-1:0]   wr_win;
  lut_addr_t          wr_addr;
  logic [NUM_WIN-1:0] ovr_flags;

  lut_burst_ctl #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (upd_start),
    .s_win      (upd_win),
    .s_first    (upd_first),
    .s_len      (upd_len),
    .s_ovr      (upd_override),
    .word_valid (upd_word_valid),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_win     (wr_win),
    .wr_addr    (wr_addr),
    .ovr_flags  (ovr_flags)
  );

  lut_addr_t rd_addr [NUM_CH];

  lut_addr_gen u_addr (
    .mode  (pix_mode),
    .index (pix_index),
    .rgb   (pix_rgb),
    .addr  (rd_addr)
  );

  logic [UPD_W-1:0] upd_word [NUM_CH];
  ent_t             rd_data  [NUM_CH];

  assign upd_word[0] = upd_red;
  assign upd_word[1] = upd_green;
  assign upd_word[2] = upd_blue;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    lut_bank #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_win  (wr_win),
      .wr_addr (wr_addr),
      .wr_data (word_to_entry(upd_word[c])),
      .rd_en   (pix_valid),
      .rd_win  (pix_win),
      .rd_addr (rd_addr[c]),
      .rd_data (rd_data[c])
    );
  end

  logic valid_q;
  logic casc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      casc_q  <= 1'b0;
    end else begin
      valid_q <= pix_valid;
      if (pix_valid) casc_q <= ~ovr_flags[pix_win];
    end
  end

  assign upd_busy    = busy;
  assign out_valid   = valid_q;
  assign out_cascade = casc_q;
  assign out_rgb     = {rd_data[0], rd_data[1], rd_data[2]};

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  // R10
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_rgb) && $stable(out_cascade));
endmodule

// File: tb/sim_win_color_lut.sv
`timescale 1ns/1ps
module sim_win_color_lut;
  localparam int NW   = 2;
  localparam int M_I1 = 0;
  localparam int M_I2 = 1;
  localparam int M_I4 = 2;
  localparam int M_I8 = 3;
  localparam int M_TC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [0:0]  pix_win = '0;
  logic [2:0]  pix_mode = '0;
  logic [7:0]  pix_index = '0;
  logic [23:0] pix_rgb = '0;
  logic        upd_start = 1'b0;
  logic [0:0]  upd_win = '0;
  logic [7:0]  upd_first = '0;
  logic [8:0]  upd_len = '0;
  logic        upd_override = 1'b0;
  logic        upd_word_valid = 1'b0;
  logic [15:0] upd_red = '0;
  logic [15:0] upd_green = '0;
  logic [15:0] upd_blue = '0;
  logic        upd_busy;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic        out_cascade;

  win_color_lut #(.NUM_WIN(NW)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: plain arrays and counters.
  int tbl [NW][3][256];
  bit m_ovr [NW];
  bit m_busy, m_valid, m_casc;
  int m_rgb, m_ptr, m_left, m_win;
  int t_w, t_bits, t_a, t_room, t_eff;
  int a_r, a_g, a_b;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_casc = 0; m_rgb = 0;
      foreach (m_ovr[w]) m_ovr[w] = 0;
    end else begin
      m_valid = pix_valid;
      if (pix_valid) begin
        t_w = int'(pix_win);
        if (pix_mode >= 3'd4) begin
          a_r = pix_rgb[23:16]; a_g = pix_rgb[15:8]; a_b = pix_rgb[7:0];
        end else begin
          t_bits = 1 << pix_mode;
          t_a = int'(pix_index) & ((1 << t_bits) - 1);
          a_r = t_a; a_g = t_a; a_b = t_a;
        end
        m_rgb  = (tbl[t_w][0][a_r] << 16) | (tbl[t_w][1][a_g] << 8) | tbl[t_w][2][a_b];
        m_casc = !m_ovr[t_w];
      end
      if (m_busy) begin
        if (upd_word_valid) begin
          tbl[m_win][0][m_ptr] = int'(upd_red[15:8]);
          tbl[m_win][1][m_ptr] = int'(upd_green[15:8]);
          tbl[m_win][2][m_ptr] = int'(upd_blue[15:8]);
          m_ptr++;
          m_left--;
          if (m_left == 0) m_busy = 0;
        end
      end else if (upd_start) begin
        m_ovr[upd_win] = upd_override;
        t_room = 256 - int'(upd_first);
        t_eff  = (int'(upd_len) < t_room) ? int'(upd_len) : t_room;
        if (t_eff > 0) begin
          m_busy = 1; m_ptr = int'(upd_first); m_left = t_eff; m_win = int'(upd_win);
        end
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    chk("R10", int'(out_valid), int'(m_valid));
    chk("R6", int'(upd_busy), int'(m_busy));
    chk(cur_req, int'(out_rgb), m_rgb);
    chk("R9", int'(out_cascade), int'(m_casc));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R6 watchdog: got %0d cycles expected fewer than 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int pv(int pat, int ch, int i);
    return (i * 7 + pat * 31 + ch * 85 + (i >> 3)) & 255;
  endfunction

  function automatic int pcol(int pat, int i);
    return (pv(pat, 0, i) << 16) | (pv(pat, 1, i) << 8) | pv(pat, 2, i);
  endfunction

  task automatic set_words(int pat, int i);
    logic [7:0] v0, v1, v2;
    v0 = 8'(pv(pat, 0, i & 255));
    v1 = 8'(pv(pat, 1, i & 255));
    v2 = 8'(pv(pat, 2, i & 255));
    // Odd patterns duplicate the byte; even ones put noise in the low byte.
    if (pat % 2 == 1) begin
      upd_red = {v0, v0}; upd_green = {v1, v1}; upd_blue = {v2, v2};
    end else begin
      upd_red = {v0, v0 ^ 8'hA5}; upd_green = {v1, ~v1}; upd_blue = {v2, v2 ^ 8'h3C};
    end
  endtask

  task automatic burst(int w, int first, int len, bit ovr, int pat, int nwords,
                       bit gaps, bit exp_busy);
    @(negedge clk);
    upd_start = 1; upd_win = 1'(w); upd_first = 8'(first);
    upd_len = 9'(len); upd_override = ovr;
    @(negedge clk);
    upd_start = 0;
    chk(exp_busy ? "R6" : "R7", int'(upd_busy), int'(exp_busy));
    for (int i = 0; i < nwords; i++) begin
      upd_word_valid = 1;
      set_words(pat, first + i);
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        upd_word_valid = 0;
        @(negedge clk);
      end
    end
    upd_word_valid = 0;
  endtask

  task automatic look(int w, int mode, int idx, int rgb, output int o_rgb, output int o_c);
    @(negedge clk);
    pix_valid = 1; pix_win = 1'(w); pix_mode = 3'(mode);
    pix_index = 8'(idx); pix_rgb = 24'(rgb);
    @(negedge clk);
    pix_valid = 0;
    o_rgb = int'(out_rgb);
    o_c = int'(out_cascade);
  endtask

  initial begin
    int r, c;
    repeat (3) @(negedge clk);
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_rgb), 0);
    chk("R1", int'(upd_busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(upd_busy), 0);

    // R6 full fills, window 1 with gaps and noisy low bytes (R5)
    cur_req = "R6";
    burst(0, 0, 256, 0, 1, 256, 0, 1);
    chk("R6", int'(upd_busy), 0);
    burst(1, 0, 256, 1, 2, 256, 1, 1);
    chk("R6", int'(upd_busy), 0);

    // R2 index masking per mode, all with high bits set
    cur_req = "R2";
    look(0, M_I1, 8'hFF, 0, r, c); chk("R2", r, pcol(1, 1));
    look(0, M_I2, 8'hFE, 0, r, c); chk("R2", r, pcol(1, 2));
    look(0, M_I4, 8'hF9, 0, r, c); chk("R2", r, pcol(1, 9));
    look(0, M_I8, 8'hC7, 0, r, c); chk("R2", r, pcol(1, 199));
    chk("R9", c, 1);
    // R5 upper byte kept
    look(1, M_I8, 77, 0, r, c); chk("R5", r, pcol(2, 77));
    chk("R9", c, 0);

    // R3 channels independent
    cur_req = "R3";
    look(0, M_TC, 0, 24'h10_20_30, r, c);
    chk("R3", r, (pv(1, 0, 16) << 16) | (pv(1, 1, 32) << 8) | pv(1, 2, 48));
    look(1, 7, 0, 24'hFF_00_80, r, c);
    chk("R3", r, (pv(2, 0, 255) << 16) | (pv(2, 1, 0) << 8) | pv(2, 2, 128));

    // R10 latency
    @(negedge clk);
    pix_valid = 1; pix_win = 0; pix_mode = 3'(M_I8); pix_index = 8'd3;
    @(negedge clk);
    pix_valid = 0;
    chk("R10", int'(out_valid), 1);
    chk("R10", int'(out_rgb), pcol(1, 3));
    @(negedge clk);
    chk("R10", int'(out_valid), 0);
    chk("R10", int'(out_rgb), pcol(1, 3));

    // Mixed streams against the model
    cur_req = "R2";
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      pix_valid = 1'($urandom % 4 != 0); pix_win = 1'($urandom);
      pix_mode = 3'($urandom % 4); pix_index = 8'($urandom); pix_rgb = 24'($urandom);
    end
    @(negedge clk); cur_req = "R3";
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      pix_valid = 1'($urandom % 4 != 0); pix_win = 1'($urandom);
      pix_mode = 3'(4 + $urandom % 4); pix_index = 8'($urandom); pix_rgb = 24'($urandom);
    end
    @(negedge clk); pix_valid = 0;

    // R7 zero length: flag only; then idle words ignored (R11)
    cur_req = "R7";
    burst(1, 5, 0, 0, 3, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      upd_word_valid = 1; set_words(5, k + 5);
      @(negedge clk);
    end
    upd_word_valid = 0;
    chk("R7", int'(upd_busy), 0);
    look(1, M_I8, 5, 0, r, c);
    chk("R11", r, pcol(2, 5));
    chk("R7", c, 1);

    // R8 clamp at the last entry, extra words ignored
    cur_req = "R8";
    burst(0, 250, 20, 0, 4, 8, 0, 1);
    chk("R8", int'(upd_busy), 0);
    look(0, M_I8, 252, 0, r, c); chk("R8", r, pcol(4, 252));
    look(0, M_I8, 255, 0, r, c); chk("R8", r, pcol(4, 255));
    look(0, M_I8, 0, 0, r, c);   chk("R8", r, pcol(1, 0));
    look(0, M_I8, 1, 0, r, c);   chk("R11", r, pcol(1, 1));
    look(0, M_I8, 249, 0, r, c); chk("R8", r, pcol(1, 249));
    // R4 other window untouched
    look(1, M_I8, 252, 0, r, c); chk("R4", r, pcol(2, 252));

    // R11 start while busy is ignored
    cur_req = "R11";
    @(negedge clk);
    upd_start = 1; upd_win = 1; upd_first = 8'd100; upd_len = 9'd10; upd_override = 0;
    @(negedge clk);
    upd_start = 0;
    for (int i = 0; i < 10; i++) begin
      upd_word_valid = 1; set_words(5, 100 + i);
      if (i == 3) begin
        upd_start = 1; upd_first = 8'd0; upd_len = 9'd50; upd_override = 1;
      end else begin
        upd_start = 0;
      end
      @(negedge clk);
    end
    upd_start = 0; upd_word_valid = 0;
    chk("R11", int'(upd_busy), 0);
    look(1, M_I8, 0, 0, r, c);   chk("R11", r, pcol(2, 0));
    chk("R11", c, 1);
    look(1, M_I8, 109, 0, r, c); chk("R6", r, pcol(5, 109));
    look(0, M_I8, 109, 0, r, c); chk("R4", r, pcol(1, 109));

    // R10 reads colliding with writes return old data
    cur_req = "R10";
    fork
      burst(0, 10, 4, 0, 6, 4, 0, 1);
      begin
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          pix_valid = 1; pix_win = 0; pix_mode = 3'(M_I8); pix_index = 8'(10 + i);
          @(negedge clk);
          chk("R10", int'(out_rgb), pcol(1, 10 + i));
        end
        pix_valid = 0;
      end
    join
    look(0, M_I8, 12, 0, r, c); chk("R10", r, pcol(6, 12));

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule